// File: doc/BRIEF.md
# Pipelined Pixel Data Serializer

This block sits between a per-pixel converter and a single shared serial data line. Every pixel period is marked by a sample strobe. On each high-to-low transition of that strobe, the block takes in the converter's 8-bit result and moves it through a two-deep holding pipeline. In the same step it parallel-loads the oldest held result into an output shift register. The most significant bit is on the data line straight after the strobe edge, with no serial clock needed. Each following rising edge of the serial clock presents the next lower bit.

A direction input selects between read mode, where the block drives the line, and write mode, where the line belongs to another agent and the block drives nothing. The strobe and the serial clock reach the block as levels. The block samples them on the system clock and acts on their edges, so the whole design is one clock domain.

A result captured at strobe edge k is loaded for shifting at edge k+2. This gives a fixed latency of two pixel periods. After the last bit, any extra serial clock edges move zeros onto the line.

Top module: `pixel_serializer`

## Requirements
- R1: After synchronous reset, both holding stages and the shift register are zero. The first two words read after reset are 0x00, and `ser_dout` is 0.
- R2: `ser_oe` is high exactly when `rd_mode` is high. While `rd_mode` is low, `ser_dout` is held at 0.
- R3: A strobe fall is `samp_strobe` sampled high on one clock edge and low on the next. At a strobe fall, the shift register loads the result captured two falls earlier. Its bit 7 appears on `ser_dout` in the cycle after that clock edge.
- R4: A strobe fall captures `conv_data` into the first holding stage only when `conv_valid` is high. Otherwise 0x00 enters the pipeline in its place.
- R5: In read mode, each rising edge of `ser_clk` (low on one clock edge, high on the next) shifts the word toward the MSB. Bits 6 down to 0 appear in order.
- R6: After bit 0 has been presented, any further `ser_clk` rising edges put 0 on `ser_dout`.
- R7: In write mode, `ser_clk` rising edges do not shift. A word loaded earlier is still read out whole, from bit 7, once read mode returns.
- R8: The holding pipeline advances on every strobe fall in either mode, and on no other event.
- R9: When a strobe fall and a `ser_clk` rising edge land on the same clock edge, the load wins. `ser_dout` then shows bit 7 of the newly loaded word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_data | input | 8 | Converter result for the current pixel |
| conv_valid | input | 1 | Qualifies `conv_data` at the strobe fall |
| samp_strobe | input | 1 | Per-pixel sample strobe, acted on at its falling edge |
| ser_clk | input | 1 | Serial clock, acted on at its rising edge |
| rd_mode | input | 1 | High: read mode, block drives data; low: write mode |
| ser_dout | output | 1 | Serial data out, MSB first |
| ser_oe | output | 1 | Output enable for the shared data line |

## Verification
The assertions take for granted that `samp_strobe` and `ser_clk` are synchronous to `clk` and stay at each level for at least one clock. Edges are defined by consecutive samples, so a shorter pulse would simply not exist for either the design or the checks. The stimulus changes every input on the falling clock edge and holds each strobe and serial clock level for at least one full cycle. It also keeps `conv_data` stable across each strobe fall. The one deliberate overlap, where a strobe fall and a serial clock rise land together, is there to exercise the priority in R9.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

    localparam int unsigned PIX_W     = 8;
    localparam int unsigned HOLD_DEPTH = 2;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic load;
        logic shift;
    } ser_evt_t;

    function automatic logic [PIX_W-1:0] capture_word(input logic [PIX_W-1:0] d,
                                                      input logic           v);
        return v ? d : '0;
    endfunction

endpackage

// File: rtl/pixser_edge.sv
module pixser_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic edge_pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_pulse = level_in & ~prev_q;
        end else begin : g_fall
            assign edge_pulse = ~level_in & prev_q;
        end
    endgenerate
endmodule

// File: rtl/pixser_hold.sv
module pixser_hold
    import pixser_pkg::*;
#(
    parameter int unsigned W     = PIX_W,
    parameter int unsigned DEPTH = HOLD_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    output logic [W-1:0] oldest
);
    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)          stage_q[0] <= '0;
        else if (advance) stage_q[0] <= capture_word(in_word, in_valid);
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)          stage_q[i] <= '0;
                else if (advance) stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign oldest = stage_q[DEPTH-1];
endmodule

// File: rtl/pixser_shifter.sv
module pixser_shifter
    import pixser_pkg::*;
#(
    parameter int unsigned W = PIX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ser_evt_t     evt,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst)            word_q <= '0;
        else if (evt.load)  word_q <= load_word;
        else if (evt.shift) word_q <= {word_q[W-2:0], 1'b0};
    end
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pixser_pkg::*;
#(
    parameter int unsigned W     = PIX_W,
    parameter int unsigned DEPTH = HOLD_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] conv_data,
    input  logic         conv_valid,
    input  logic         samp_strobe,
    input  logic         ser_clk,
    input  logic         rd_mode,
    output logic         ser_dout,
    output logic         ser_oe
);
    localparam int unsigned MSB = W - 1;

    logic     strobe_fall;
    logic     sclk_rise;
    ser_evt_t evt;
    logic [W-1:0] hold_last;
    logic [W-1:0] shift_word;
    dir_e     dir;

    assign dir = dir_e'(rd_mode);

    pixser_edge #(.RISING(1'b0)) u_strobe_edge (
        .clk(clk), .rst(rst), .level_in(samp_strobe), .edge_pulse(strobe_fall)
    );

    pixser_edge #(.RISING(1'b1)) u_sclk_edge (
        .clk(clk), .rst(rst), .level_in(ser_clk), .edge_pulse(sclk_rise)
    );

    pixser_hold #(.W(W), .DEPTH(DEPTH)) u_hold (
        .clk(clk), .rst(rst), .advance(strobe_fall),
        .in_word(conv_data), .in_valid(conv_valid), .oldest(hold_last)
    );

    always_comb begin
        evt.load  = strobe_fall;
        evt.shift = sclk_rise && (dir == DIR_READ);
    end

    pixser_shifter #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .evt(evt), .load_word(hold_last), .word_q(shift_word)
    );

    assign ser_oe   = (dir == DIR_READ);
    assign ser_dout = (dir == DIR_READ) ? shift_word[MSB] : 1'b0;
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         samp_strobe,
    input logic         ser_clk,
    input logic         rd_mode,
    input logic         ser_dout,
    input logic         ser_oe,
    input logic [W-1:0] hold_last,
    input logic [W-1:0] shift_word
);
    logic strobe_d, sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            sclk_d   <= 1'b0;
        end else begin
            strobe_d <= samp_strobe;
            sclk_d   <= ser_clk;
        end
    end

    wire fall_seen = strobe_d && !samp_strobe;
    wire rise_seen = !sclk_d && ser_clk;

    // R2: line quiet when not driven
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !ser_oe |-> !ser_dout);

    // R2: enable tracks direction
    a_r2_oe_direction: assert property (@(posedge clk) disable iff (rst)
        rd_mode |-> ser_oe);

    // R3 / R9: load on strobe fall, taking priority over a shift
    a_r3_load_oldest: assert property (@(posedge clk) disable iff (rst)
        fall_seen |=> shift_word == $past(hold_last));

    // R5: one bit shift per serial clock rise in read mode
    a_r5_shift_one: assert property (@(posedge clk) disable iff (rst)
        (rise_seen && rd_mode && !fall_seen) |=> shift_word == ($past(shift_word) << 1));

    // R7: no movement without a load or read-mode shift
    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!fall_seen && !(rise_seen && rd_mode)) |=> $stable(shift_word));

    // R8: holding pipeline moves only on a strobe fall
    a_r8_pipe_still: assert property (@(posedge clk) disable iff (rst)
        !fall_seen |=> $stable(hold_last));
endmodule

bind pixel_serializer pixel_serializer_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .samp_strobe(samp_strobe), .ser_clk(ser_clk),
    .rd_mode(rd_mode), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .hold_last(hold_last), .shift_word(shift_word)
);

// File: tb/pixel_serializer_test.sv
module pixel_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] conv_data = '0;
    logic       conv_valid = 1'b0;
    logic       samp_strobe = 1'b0;
    logic       ser_clk = 1'b0;
    logic       rd_mode = 1'b0;
    logic       ser_dout;
    logic       ser_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] model_s0 = '0;
    logic [7:0] model_s1 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_serializer uut (
        .clk(clk), .rst(rst), .conv_data(conv_data), .conv_valid(conv_valid),
        .samp_strobe(samp_strobe), .ser_clk(ser_clk), .rd_mode(rd_mode),
        .ser_dout(ser_dout), .ser_oe(ser_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one pixel period, ending on a strobe fall; pushes the expected word.
    task automatic drive_pixel(input logic [7:0] d, input logic v, input bit with_sclk);
        @(negedge clk);
        conv_data   = d;
        conv_valid  = v;
        samp_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        samp_strobe = 1'b0;
        if (with_sclk) ser_clk = 1'b1;
        exp_q.push_back(model_s1);
        model_s1 = model_s0;
        model_s0 = v ? d : 8'h00;
        @(negedge clk);
    endtask

    task automatic sclk_pulse(output logic bit_seen);
        ser_clk = 1'b1;
        @(negedge clk);
        bit_seen = ser_dout;
        ser_clk = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: collects one word from the line and compares with the scoreboard.
    task automatic read_word(input string req, input bit extra);
        logic [7:0] got;
        logic [7:0] want;
        logic b;
        got[7] = ser_dout;
        if (ser_clk) begin
            ser_clk = 1'b0;
            @(negedge clk);
        end
        for (int i = 6; i >= 0; i--) begin
            sclk_pulse(b);
            got[i] = b;
        end
        want = exp_q.pop_front();
        check(req, got, want);
        if (extra) begin
            sclk_pulse(b);
            check("R6 extra edge 1", {7'b0, b}, 8'h00);
            sclk_pulse(b);
            check("R6 extra edge 2", {7'b0, b}, 8'h00);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset dout", {7'b0, ser_dout}, 8'h00);
        check("R2 oe low in write", {7'b0, ser_oe}, 8'h00);
        rd_mode = 1'b1;
        @(negedge clk);
        check("R2 oe high in read", {7'b0, ser_oe}, 8'h01);
        check("R1 reset shift word", {7'b0, ser_dout}, 8'h00);

        drive_pixel(8'hA5, 1'b1, 1'b0);
        read_word("R1 first word zero", 1'b0);
        drive_pixel(8'h3C, 1'b1, 1'b0);
        read_word("R1 second word zero", 1'b0);
        drive_pixel(8'hFF, 1'b1, 1'b0);
        read_word("R3 two-period latency", 1'b1);
        drive_pixel(8'h81, 1'b0, 1'b0);
        read_word("R5 msb first order", 1'b0);
        drive_pixel(8'h5A, 1'b1, 1'b0);
        read_word("R3 all ones word", 1'b0);
        drive_pixel(8'h66, 1'b1, 1'b0);
        read_word("R4 invalid gives zero", 1'b0);

        // R8: fall in write mode still advances; R7: no shifting there
        rd_mode = 1'b0;
        drive_pixel(8'hC3, 1'b1, 1'b0);
        check("R2 dout quiet in write", {7'b0, ser_dout}, 8'h00);
        check("R2 oe low again", {7'b0, ser_oe}, 8'h00);
        repeat (3) sclk_pulse(b);
        check("R2 dout quiet after sclk", {7'b0, b}, 8'h00);
        rd_mode = 1'b1;
        @(negedge clk);
        read_word("R7 word intact after write-mode sclk", 1'b0);

        // idle with sclk pulses: pipeline must not move (R8)
        repeat (2) sclk_pulse(b);
        drive_pixel(8'h11, 1'b1, 1'b1);
        read_word("R9 load beats shift", 1'b0);
        drive_pixel(8'h22, 1'b1, 1'b0);
        read_word("R8 pipeline advanced in write mode", 1'b0);
        drive_pixel(8'h33, 1'b1, 1'b0);
        read_word("R8 pipeline order kept", 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule